// File: doc/BRIEF.md
# NAND flash operation sequencer

This block sits between a register bus and the pins of a NAND flash device. Software loads a command byte or an address byte into a holding register and then writes a one-hot trigger into the operation register. The sequencer then runs exactly one bus operation: a command latch cycle, an address latch cycle, a page program fed from the page buffer, a page read into the page buffer, an ID read, or a status read.

Every strobe has setup, low and hold phases whose lengths are set in clock counts by parameters. After the last strobe the sequencer waits a guard interval and then waits for the ready/busy line to show ready. Only then does it raise a sticky done flag. The done flag drives a maskable interrupt. A chip-enable bit and a chip-number field choose one chip-select line. A self-clearing soft reset aborts whatever operation is running. A spare-size register, given in 16-bit words, sets how many spare bytes follow the main page in a page transfer.

Register map (3-bit register address): 0 command byte, 1 address byte, 2 operation, 3 configuration, 4 chip select, 5 spare size.

Top module: `nand_op_seq`

## Requirements
- R1: After reset, WE# and RE# are high, CLE and ALE are low, every chip-select line is high and irq is low. The operation register reads 0x0000 and the configuration register reads 0x0010, which means the interrupt starts masked.
- R2: Operation bit 0 runs one WE# pulse, T_PULSE clocks long, with CLE high and the command byte (register 0) on the data bus. Operation bit 1 does the same with ALE high and the address byte (register 1).
- R3: Operation bit 4 runs ID_BYTES RE# pulses and stores the captured bytes at buffer addresses 0 upward. Operation bit 5 runs one RE# pulse and stores its byte at buffer address 0. WE# and RE# are never low together.
- R4: Bit 15 of the operation register sets when an operation completes. It stays set until software writes the operation register with bit 15 at 0.
- R5: irq is high exactly when the done flag is set and configuration bit 4 (mask) is 0.
- R6: Chip-select line n is low only when configuration bit 7 is 1 and chip-select register bits 6:5 equal n. At most one line is low at any time.
- R7: An operation completes only after a guard of T_GUARD clocks following its last strobe, and only once the ready/busy input is high.
- R8: Operation bit 3 runs PAGE_BYTES plus twice the spare-size value RE# pulses and writes the bytes to buffer addresses 0 upward. Operation bit 2 runs the same number of WE# pulses and drives the buffer bytes from address 0 upward.
- R9: The spare-size register (register 5, SPARE_BITS wide) holds a word count and reads back the value that was written.
- R10: A trigger written while an operation is running is ignored. When several trigger bits are set, only the lowest one runs.
- R11: Writing configuration bit 6 as 1 aborts the running operation and clears the done flag. Bit 6 reads 1 for SRST_CYCLES clocks and then returns to 0 by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data for regAddr |
| irq | output | 1 | Completion interrupt |
| nandCeN | output | NUM_CS | Active-low chip selects |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Active-low write strobe |
| nandReN | output | 1 | Active-low read strobe |
| nandDqOut | output | 8 | Data bus drive value |
| nandDqOe | output | 1 | Data bus drive enable |
| nandDqIn | input | 8 | Data bus sampled value |
| nandRbN | input | 1 | Ready (1) / busy (0) |
| bufAddr | output | BUF_AW | Page buffer byte address |
| bufWrEn | output | 1 | Page buffer write strobe |
| bufWrData | output | 8 | Page buffer write data |
| bufRdData | input | 8 | Page buffer read data at bufAddr |

## Verification
The spare size is swept from 0 to 4 words so that page-read strobe counts and buffer fill patterns show the main/spare length arithmetic is right, not merely that some strobes appear. Each strobe gets a distinct data byte from an incrementing counter, so a shifted buffer address or a dropped capture shows up. A page program from a non-repeating buffer pattern checks the program direction the same way. Multi-bit triggers (command plus address, ID plus status) check the priority rule. A trigger written while busy, with ready/busy held low, separates an ignored trigger from a queued one and shows that completion waits for ready.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  // Enum values equal the trigger bit positions in the operation register
  typedef enum logic [2:0] {
    OP_CMD  = 3'd0,
    OP_ADDR = 3'd1,
    OP_PROG = 3'd2,
    OP_READ = 3'd3,
    OP_ID   = 3'd4,
    OP_STAT = 3'd5
  } opKind_t;

  typedef struct packed {
    logic busy;
    logic cle;
    logic ale;
    logic dqOe;
    logic weLow;
    logic reLow;
    logic capture;
    logic nextByte;
    logic finish;
  } seqStrobe_t;

  localparam logic [2:0] REG_CMD   = 3'd0;
  localparam logic [2:0] REG_ADDR  = 3'd1;
  localparam logic [2:0] REG_OP    = 3'd2;
  localparam logic [2:0] REG_CFG   = 3'd3;
  localparam logic [2:0] REG_CS    = 3'd4;
  localparam logic [2:0] REG_SPARE = 3'd5;

endpackage

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
  import nand_seq_pkg::*;
#(
  parameter int T_SETUP = 1,
  parameter int T_PULSE = 2,
  parameter int T_HOLD  = 1,
  parameter int T_GUARD = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       softRst,
  input  logic       launch,
  input  opKind_t    launchOp,
  input  logic       lastByte,
  input  logic       rbN,
  output seqStrobe_t st
);

  localparam int TMAX_A = (T_SETUP > T_PULSE) ? T_SETUP : T_PULSE;
  localparam int TMAX_B = (TMAX_A > T_HOLD) ? TMAX_A : T_HOLD;
  localparam int TMAX   = (TMAX_B > T_GUARD) ? TMAX_B : T_GUARD;
  localparam int CW     = $clog2(TMAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_PULSE, S_HOLD, S_GUARD, S_WAIT} state_t;

  state_t        state;
  opKind_t       op;
  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;
  logic          phaseEnd;
  logic          isRead;
  logic          inStrobe;

  always_comb begin
    case (state)
      S_SETUP: limit = CW'(T_SETUP);
      S_PULSE: limit = CW'(T_PULSE);
      S_HOLD:  limit = CW'(T_HOLD);
      S_GUARD: limit = CW'(T_GUARD);
      default: limit = CW'(1);
    endcase
  end

  assign phaseEnd = (cnt == limit - 1'b1);
  assign isRead   = (op == OP_READ) || (op == OP_ID) || (op == OP_STAT);
  assign inStrobe = (state == S_SETUP) || (state == S_PULSE) || (state == S_HOLD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      op    <= OP_CMD;
      cnt   <= '0;
    end else if (softRst) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE: if (launch) begin
          state <= S_SETUP;
          op    <= launchOp;
          cnt   <= '0;
        end
        S_SETUP, S_PULSE, S_GUARD: begin
          if (phaseEnd) begin
            cnt <= '0;
            if (state == S_SETUP)      state <= S_PULSE;
            else if (state == S_PULSE) state <= S_HOLD;
            else                       state <= S_WAIT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_HOLD: begin
          if (phaseEnd) begin
            cnt   <= '0;
            state <= lastByte ? S_GUARD : S_SETUP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_WAIT: if (rbN) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    st          = '0;
    st.busy     = (state != S_IDLE);
    st.cle      = inStrobe && (op == OP_CMD);
    st.ale      = inStrobe && (op == OP_ADDR);
    st.dqOe     = inStrobe && !isRead;
    st.weLow    = (state == S_PULSE) && !isRead;
    st.reLow    = (state == S_PULSE) && isRead;
    st.capture  = (state == S_PULSE) && isRead && phaseEnd;
    st.nextByte = (state == S_HOLD) && phaseEnd && !lastByte;
    st.finish   = (state == S_WAIT) && rbN;
  end

endmodule

// File: rtl/nand_seq_dp.sv
module nand_seq_dp
  import nand_seq_pkg::*;
#(
  parameter int CS_BITS     = 2,
  parameter int BUF_AW      = 8,
  parameter int SPARE_BITS  = 6,
  parameter int PAGE_BYTES  = 16,
  parameter int ID_BYTES    = 4,
  parameter int SRST_CYCLES = 8,
  localparam int NUM_CS     = 1 << CS_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [15:0]       regWrData,
  output logic [15:0]       regRdData,
  output logic              irq,
  input  seqStrobe_t        st,
  output logic              launch,
  output opKind_t           launchOp,
  output logic              lastByte,
  output logic              softRst,
  output logic              doneFlag,
  output logic [NUM_CS-1:0] nandCeN,
  output logic              nandCle,
  output logic              nandAle,
  output logic              nandWeN,
  output logic              nandReN,
  output logic [7:0]        nandDqOut,
  output logic              nandDqOe,
  input  logic [7:0]        nandDqIn,
  output logic [BUF_AW-1:0] bufAddr,
  output logic              bufWrEn,
  output logic [7:0]        bufWrData,
  input  logic [7:0]        bufRdData
);

  localparam int IW = BUF_AW + 1;
  localparam int RW = $clog2(SRST_CYCLES + 1);

  logic [7:0]            cmdByte, addrByte;
  logic                  irqMask, chipEn;
  logic [CS_BITS-1:0]    chipSel;
  logic [SPARE_BITS-1:0] spareWords;
  logic [RW-1:0]         srstCnt;
  opKind_t               curOp;
  logic [IW-1:0]         byteIdx, byteTotal;
  logic                  wrOp, wrCfg;

  assign wrOp  = regWrEn && (regAddr == REG_OP);
  assign wrCfg = regWrEn && (regAddr == REG_CFG);

  // Lowest set trigger bit wins
  always_comb begin
    launchOp = OP_CMD;
    for (int i = 5; i >= 0; i--)
      if (regWrData[i]) launchOp = opKind_t'(3'(i));
  end

  assign launch = wrOp && (|regWrData[5:0]) && !st.busy && !softRst;

  always_comb begin
    case (curOp)
      OP_PROG, OP_READ: byteTotal = IW'(PAGE_BYTES) + (IW'(spareWords) << 1);
      OP_ID:            byteTotal = IW'(ID_BYTES);
      default:          byteTotal = IW'(1);
    endcase
  end

  assign lastByte = (byteIdx == byteTotal - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdByte    <= '0;
      addrByte   <= '0;
      irqMask    <= 1'b1;
      chipEn     <= 1'b0;
      chipSel    <= '0;
      spareWords <= '0;
      curOp      <= OP_CMD;
      byteIdx    <= '0;
      doneFlag   <= 1'b0;
      softRst    <= 1'b0;
      srstCnt    <= '0;
    end else begin
      if (regWrEn && regAddr == REG_CMD)   cmdByte    <= regWrData[7:0];
      if (regWrEn && regAddr == REG_ADDR)  addrByte   <= regWrData[7:0];
      if (regWrEn && regAddr == REG_CS)    chipSel    <= regWrData[5 +: CS_BITS];
      if (regWrEn && regAddr == REG_SPARE) spareWords <= regWrData[SPARE_BITS-1:0];
      if (wrCfg) begin
        irqMask <= regWrData[4];
        chipEn  <= regWrData[7];
      end
      if (launch) begin
        curOp   <= launchOp;
        byteIdx <= '0;
      end else if (st.nextByte) begin
        byteIdx <= byteIdx + 1'b1;
      end
      // Soft reset window
      if (wrCfg && regWrData[6] && !softRst) begin
        softRst <= 1'b1;
        srstCnt <= '0;
      end else if (softRst) begin
        if (srstCnt == RW'(SRST_CYCLES - 1)) softRst <= 1'b0;
        srstCnt <= srstCnt + 1'b1;
      end
      // Sticky completion flag
      if (softRst)               doneFlag <= 1'b0;
      else if (st.finish)        doneFlag <= 1'b1;
      else if (wrOp && !regWrData[15]) doneFlag <= 1'b0;
    end
  end

  assign irq = doneFlag && !irqMask;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_ce
    assign nandCeN[g] = !(chipEn && (chipSel == CS_BITS'(g)));
  end

  assign nandCle   = st.cle;
  assign nandAle   = st.ale;
  assign nandWeN   = !st.weLow;
  assign nandReN   = !st.reLow;
  assign nandDqOe  = st.dqOe;
  assign nandDqOut = (curOp == OP_CMD)  ? cmdByte :
                     (curOp == OP_ADDR) ? addrByte : bufRdData;

  assign bufAddr   = byteIdx[BUF_AW-1:0];
  assign bufWrEn   = st.capture;
  assign bufWrData = nandDqIn;

  always_comb begin
    case (regAddr)
      REG_CMD:   regRdData = {8'h00, cmdByte};
      REG_ADDR:  regRdData = {8'h00, addrByte};
      REG_OP:    regRdData = {doneFlag, 15'h0000};
      REG_CFG:   regRdData = {8'h00, chipEn, softRst, 1'b0, irqMask, 4'h0};
      REG_CS:    regRdData = 16'((32'(chipSel)) << 5);
      REG_SPARE: regRdData = 16'(spareWords);
      default:   regRdData = 16'h0000;
    endcase
  end

endmodule

// File: rtl/nand_op_seq.sv
module nand_op_seq
  import nand_seq_pkg::*;
#(
  parameter int CS_BITS     = 2,
  parameter int BUF_AW      = 8,
  parameter int SPARE_BITS  = 6,
  parameter int PAGE_BYTES  = 16,
  parameter int ID_BYTES    = 4,
  parameter int SRST_CYCLES = 8,
  parameter int T_SETUP     = 1,
  parameter int T_PULSE     = 2,
  parameter int T_HOLD      = 1,
  parameter int T_GUARD     = 2,
  localparam int NUM_CS     = 1 << CS_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [15:0]       regWrData,
  output logic [15:0]       regRdData,
  output logic              irq,
  output logic [NUM_CS-1:0] nandCeN,
  output logic              nandCle,
  output logic              nandAle,
  output logic              nandWeN,
  output logic              nandReN,
  output logic [7:0]        nandDqOut,
  output logic              nandDqOe,
  input  logic [7:0]        nandDqIn,
  input  logic              nandRbN,
  output logic [BUF_AW-1:0] bufAddr,
  output logic              bufWrEn,
  output logic [7:0]        bufWrData,
  input  logic [7:0]        bufRdData
);

  seqStrobe_t st;
  logic       launch, lastByte, softRst, doneFlag;
  opKind_t    launchOp;

  nand_seq_ctrl #(
    .T_SETUP(T_SETUP), .T_PULSE(T_PULSE), .T_HOLD(T_HOLD), .T_GUARD(T_GUARD)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .softRst(softRst), .launch(launch),
    .launchOp(launchOp), .lastByte(lastByte), .rbN(nandRbN), .st(st)
  );

  nand_seq_dp #(
    .CS_BITS(CS_BITS), .BUF_AW(BUF_AW), .SPARE_BITS(SPARE_BITS),
    .PAGE_BYTES(PAGE_BYTES), .ID_BYTES(ID_BYTES), .SRST_CYCLES(SRST_CYCLES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irq(irq), .st(st),
    .launch(launch), .launchOp(launchOp), .lastByte(lastByte),
    .softRst(softRst), .doneFlag(doneFlag), .nandCeN(nandCeN),
    .nandCle(nandCle), .nandAle(nandAle), .nandWeN(nandWeN),
    .nandReN(nandReN), .nandDqOut(nandDqOut), .nandDqOe(nandDqOe),
    .nandDqIn(nandDqIn), .bufAddr(bufAddr), .bufWrEn(bufWrEn),
    .bufWrData(bufWrData), .bufRdData(bufRdData)
  );

endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk
  import nand_seq_pkg::*;
#(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [2:0]        regAddr,
  input logic [15:0]       regWrData,
  input logic [NUM_CS-1:0] nandCeN,
  input logic              nandCle,
  input logic              nandAle,
  input logic              nandWeN,
  input logic              nandReN,
  input logic              nandRbN,
  input logic              finish,
  input logic              busy,
  input logic              doneFlag,
  input logic              softRst
);

  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(!nandWeN && !nandReN));

  p_latch_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(nandCle && nandAle));

  p_done_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    (doneFlag && !softRst && !(regWrEn && regAddr == REG_OP && !regWrData[15]))
    |=> doneFlag);

  p_one_chip_r6: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~nandCeN) <= 1);

  p_finish_ready_r7: assert property (@(posedge clk) disable iff (!rstN)
    finish |-> nandRbN);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (nandWeN && nandReN && !nandCle && !nandAle));

endmodule

bind nand_op_seq nand_seq_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .nandCeN(nandCeN), .nandCle(nandCle),
  .nandAle(nandAle), .nandWeN(nandWeN), .nandReN(nandReN),
  .nandRbN(nandRbN), .finish(st.finish), .busy(st.busy),
  .doneFlag(doneFlag), .softRst(softRst)
);

// File: tb/sim_nand_op_seq.sv
`timescale 1ns/1ps
module sim_nand_op_seq;

  localparam int PAGE = 16;
  localparam int IDN  = 4;
  localparam int TP   = 2;
  localparam int SRST = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        irq;
  logic [3:0]  nandCeN;
  logic        nandCle, nandAle, nandWeN, nandReN, nandDqOe;
  logic [7:0]  nandDqOut;
  logic [7:0]  nandDqIn = 8'h00;
  logic        nandRbN = 1'b1;
  logic [7:0]  bufAddr;
  logic        bufWrEn;
  logic [7:0]  bufWrData;
  logic [7:0]  bufRdData;

  logic [7:0]  progMem [256];
  logic [7:0]  capMem  [256];
  logic [7:0]  weLog   [1024];
  int          weCount = 0, reCount = 0, lowRun = 0, weWidth = 0;
  logic        weCle = 0, weAle = 0, prevWe = 1, prevRe = 1;
  int          nChecks = 0, nErrors = 0;
  bit          finished = 0;

  always #2 clk = ~clk;

  assign bufRdData = progMem[bufAddr];

  nand_op_seq #(.PAGE_BYTES(PAGE), .ID_BYTES(IDN), .T_PULSE(TP), .SRST_CYCLES(SRST)) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irq(irq),
    .nandCeN(nandCeN), .nandCle(nandCle), .nandAle(nandAle),
    .nandWeN(nandWeN), .nandReN(nandReN), .nandDqOut(nandDqOut),
    .nandDqOe(nandDqOe), .nandDqIn(nandDqIn), .nandRbN(nandRbN),
    .bufAddr(bufAddr), .bufWrEn(bufWrEn), .bufWrData(bufWrData),
    .bufRdData(bufRdData)
  );

  // Pin monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (prevWe && !nandWeN) begin
      weLog[weCount % 1024] = nandDqOut;
      weCle = nandCle;
      weAle = nandAle;
      weCount++;
    end
    if (!nandWeN) lowRun++;
    else if (!prevWe) begin weWidth = lowRun; lowRun = 0; end
    if (prevRe && !nandReN) begin
      nandDqIn = 8'(8'h30 + reCount);
      reCount++;
    end
    if (bufWrEn) capMem[bufAddr] = bufWrData;
    prevWe = nandWeN;
    prevRe = nandReN;
  end

  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", msg, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitDone();
    logic [15:0] d;
    for (int i = 0; i < 3000; i++) begin
      regRead(3'd2, d);
      if (d[15]) return;
    end
  endtask

  task automatic runOp(input logic [15:0] trig);
    regWrite(3'd2, 16'h0000);
    regWrite(3'd2, trig);
    waitDone();
  endtask

  initial begin
    #400000;
    if (!finished) begin
      nChecks++; nErrors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int base, wb, bad, total;
    for (int i = 0; i < 256; i++) progMem[i] = 8'((i * 7) ^ 8'h5C);
    for (int i = 0; i < 256; i++) capMem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(nandWeN && nandReN && !nandCle && !nandAle, "R1 strobes idle", {nandWeN, nandReN, nandCle, nandAle}, 4'b1100);
    chk(nandCeN == 4'hF && !irq, "R1 ce/irq", {nandCeN, irq}, 5'b11110);
    regRead(3'd2, d); chk(d == 16'h0000, "R1 op reg", d, 0);
    regRead(3'd3, d); chk(d == 16'h0010, "R1 cfg reg", d, 16'h0010);

    // R2 command cycle
    regWrite(3'd0, 16'h005A);
    wb = weCount;
    runOp(16'h0001);
    chk(weCount - wb == 1, "R2 cmd pulse count", weCount - wb, 1);
    chk(weLog[wb] == 8'h5A && weCle && !weAle, "R2 cmd byte/CLE", {weLog[wb], weCle, weAle}, {8'h5A, 2'b10});
    chk(weWidth == TP, "R2 WE low width", weWidth, TP);

    // R4 sticky done, R5 interrupt gating
    repeat (10) @(negedge clk);
    regRead(3'd2, d); chk(d[15], "R4 done sticky", d, 16'h8000);
    chk(!irq, "R5 irq masked", irq, 0);
    regWrite(3'd3, 16'h0000);
    chk(irq, "R5 irq unmasked", irq, 1);
    regWrite(3'd2, 16'h8000);
    regRead(3'd2, d); chk(d[15], "R4 write with bit15 keeps done", d, 16'h8000);
    regWrite(3'd2, 16'h0000);
    regRead(3'd2, d); chk(!d[15] && !irq, "R4 done cleared", {d[15], irq}, 0);
    regWrite(3'd3, 16'h0010);

    // R2 address cycle
    regWrite(3'd1, 16'h00C3);
    wb = weCount;
    runOp(16'h0002);
    chk(weCount - wb == 1 && weLog[wb] == 8'hC3 && weAle && !weCle, "R2 addr byte/ALE",
        {weLog[wb], weAle, weCle}, {8'hC3, 2'b10});

    // R3 ID read
    base = reCount;
    runOp(16'h0010);
    chk(reCount - base == IDN, "R3 ID strobe count", reCount - base, IDN);
    bad = 0;
    for (int k = 0; k < IDN; k++) if (capMem[k] != 8'(8'h30 + base + k)) bad++;
    chk(bad == 0, "R3 ID bytes in buffer", bad, 0);

    // R3 status read
    base = reCount;
    runOp(16'h0020);
    chk(reCount - base == 1 && capMem[0] == 8'(8'h30 + base), "R3 status byte", capMem[0], 8'(8'h30 + base));

    // R8 R9 page read sweep over spare sizes
    for (int s = 0; s <= 4; s++) begin
      regWrite(3'd5, 16'(s));
      regRead(3'd5, d); chk(d == 16'(s), "R9 spare readback", d, s);
      total = PAGE + 2 * s;
      base = reCount;
      runOp(16'h0008);
      chk(reCount - base == total, "R8 page read strobes", reCount - base, total);
      bad = 0;
      for (int k = 0; k < total; k++) if (capMem[k] != 8'(8'h30 + base + k)) bad++;
      chk(bad == 0, "R8 page read buffer bytes", bad, 0);
    end

    // R8 page program with spare 1
    regWrite(3'd5, 16'h0001);
    wb = weCount;
    runOp(16'h0004);
    chk(weCount - wb == PAGE + 2, "R8 program strobes", weCount - wb, PAGE + 2);
    bad = 0;
    for (int k = 0; k < PAGE + 2; k++) if (weLog[(wb + k) % 1024] != progMem[k]) bad++;
    chk(bad == 0, "R8 program data order", bad, 0);

    // R10 lowest trigger wins
    base = reCount; wb = weCount;
    runOp(16'h0030);
    chk(reCount - base == IDN && weCount == wb, "R10 ID over status", reCount - base, IDN);
    wb = weCount;
    runOp(16'h0003);
    chk(weCount - wb == 1 && weCle && !weAle, "R10 cmd over addr", {weCle, weAle}, 2'b10);

    // R7 ready wait, R10 trigger ignored while busy
    regWrite(3'd2, 16'h0000);
    nandRbN = 1'b0;
    wb = weCount;
    regWrite(3'd2, 16'h0001);
    repeat (20) @(negedge clk);
    regRead(3'd2, d); chk(!d[15], "R7 no done while busy", d, 0);
    regWrite(3'd2, 16'h0002);
    repeat (10) @(negedge clk);
    nandRbN = 1'b1;
    waitDone();
    repeat (20) @(negedge clk);
    chk(weCount - wb == 1 && weCle, "R10 busy trigger ignored", weCount - wb, 1);

    // R6 chip selects
    regWrite(3'd4, 16'h0040);
    regWrite(3'd3, 16'h0090);
    chk(nandCeN == 4'b1011, "R6 chip 2 selected", nandCeN, 4'b1011);
    regWrite(3'd4, 16'h0000);
    chk(nandCeN == 4'b1110, "R6 chip 0 selected", nandCeN, 4'b1110);
    regWrite(3'd3, 16'h0010);
    chk(nandCeN == 4'b1111, "R6 enable off", nandCeN, 4'b1111);

    // R11 soft reset
    regWrite(3'd2, 16'h0000);
    nandRbN = 1'b0;
    regWrite(3'd2, 16'h0001);
    repeat (20) @(negedge clk);
    regWrite(3'd3, 16'h0050);
    regRead(3'd3, d); chk(d[6], "R11 reset bit set", d, 16'h0050);
    repeat (SRST + 4) @(negedge clk);
    regRead(3'd3, d); chk(!d[6], "R11 reset bit self-clears", d, 16'h0010);
    nandRbN = 1'b1;
    repeat (20) @(negedge clk);
    regRead(3'd2, d); chk(!d[15], "R11 aborted op never completes", d, 0);
    wb = weCount;
    runOp(16'h0001);
    chk(weCount - wb == 1, "R11 ops work after reset", weCount - wb, 1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

endmodule